// File: doc/BRIEF.md
# Error Counter With Threshold Interrupt

This block counts link error events of one kind and tells the port interrupt controller when the count reaches a programmed level. One instance is placed per error class: symbol decode errors, CRC errors and handshake errors. Each instance has one 32-bit software register. The running count sits in the low half and the threshold in the high half, so a single read returns both.

A threshold of zero turns the interrupt off. Any nonzero threshold turns it on. Once the count steps onto the threshold value, the block sends a one-cycle pulse to the interrupt controller. Software restarts the counter by writing anything to the count half. That write zeroes the count and also sends a one-cycle clear pulse, so the controller drops the matching interrupt status. Writes are byte-enabled. Setting the threshold therefore leaves the running count untouched.

Top module: `err_thresh_counter`

## Requirements
- R1: While reset is asserted and after it is released, the count, the threshold, `thr_hit` and `stat_clear` are all zero.
- R2: `bus_rdata` returns the count in bits 15:0 and the threshold in bits 31:16, in every cycle.
- R3: Each cycle with `ev_err` high adds one to the count, unless that cycle carries a count write. The count saturates at 0xFFFF and stays there.
- R4: A write with `bus_be[0]` or `bus_be[1]` set clears the count to zero, whatever the write data. This holds even when `ev_err` is high in the same cycle.
- R5: A count-clearing write makes `stat_clear` high for exactly the following cycle. `stat_clear` is low after every other cycle.
- R6: `bus_be[2]` loads threshold bits 23:16 and `bus_be[3]` loads threshold bits 31:24 from the write data. A write with only these enables leaves the count unchanged and does not block a same-cycle increment.
- R7: When an increment makes the count equal to a nonzero threshold, `thr_hit` is high in the cycle where the new count is visible, and for that one cycle only. The comparison uses the threshold held before any write in the same cycle.
- R8: While the threshold is zero, `thr_hit` stays low.
- R9: At saturation, further error strobes do not raise `thr_hit` again, even when the threshold is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_err | input | 1 | Error event strobe, one event per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Register read value: threshold above, count below |
| thr_hit | output | 1 | One-cycle pulse when the count reaches the threshold |
| stat_clear | output | 1 | One-cycle pulse asking the controller to clear the threshold status |

## Verification
The bound checker watches the per-cycle rules in every cycle:
- the count stepping by one or holding at saturation;
- the count clearing after a count write;
- the clear pulse following each count write;
- the threshold holding when not written;
- the hit pulse lasting one cycle, matching the prior threshold, and never firing at a zero threshold.

Some behaviours need a scenario and only the bench can show them:
- byte-level loading of the threshold halves;
- a same-cycle strobe losing to a clear;
- a threshold change taking effect one cycle late;
- exactly one pulse across a full 65535-event run to saturation.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic cnt_clr;
    logic lim_wr;
    logic inc_req;
  } errcnt_req_t;

  function automatic int unsigned bytes_of(input int unsigned bits);
    return bits / BYTE_W;
  endfunction
endpackage

// File: rtl/errcnt_count.sv
module errcnt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             inc_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    inc_done = inc && !clr && (cnt_q != CNT_MAX);
    if (clr)
      cnt_nxt = '0;
    else if (inc)
      cnt_nxt = sat_step(cnt_q);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/errcnt_limit.sv
module errcnt_limit
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NB = CNT_W / BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NB-1:0]    be,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] lim_q
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lim_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (we && be[b])
        lim_q[b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/errcnt_detect.sv
module errcnt_detect #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_done,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] lim_q,
  output logic             hit_q,
  output logic             clr_q
);
  function automatic logic reaches(input logic [CNT_W-1:0] nxt,
                                   input logic [CNT_W-1:0] lim);
    return (lim != '0) && (nxt == lim);
  endfunction

  logic hit_d;
  assign hit_d = inc_done && reaches(cnt_nxt, lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      clr_q <= clr;
    end
  end
endmodule

// File: rtl/err_thresh_counter.sv
module err_thresh_counter
  import errcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned REG_W = 2 * CNT_W,
  localparam int unsigned NB_HALF = CNT_W / BYTE_W,
  localparam int unsigned NB_ALL = 2 * NB_HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_err,
  input  logic              bus_we,
  input  logic [NB_ALL-1:0] bus_be,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              thr_hit,
  output logic              stat_clear
);
  errcnt_req_t      req;
  logic             cnt_clr_w;
  logic             inc_done_w;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] lim_q;
  logic             unused_cnt_data;

  always_comb begin
    req.cnt_clr = bus_we && (|bus_be[NB_HALF-1:0]);
    req.lim_wr  = bus_we && (|bus_be[NB_ALL-1:NB_HALF]);
    req.inc_req = ev_err;
  end

  assign cnt_clr_w       = req.cnt_clr;
  assign unused_cnt_data = ^{bus_wdata[CNT_W-1:0], req.lim_wr};

  errcnt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (req.cnt_clr),
    .inc      (req.inc_req),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .inc_done (inc_done_w)
  );

  errcnt_limit #(.CNT_W(CNT_W)) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .be    (bus_be[NB_ALL-1:NB_HALF]),
    .wdata (bus_wdata[REG_W-1:CNT_W]),
    .lim_q (lim_q)
  );

  errcnt_detect #(.CNT_W(CNT_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_done (inc_done_w),
    .clr      (req.cnt_clr),
    .cnt_nxt  (cnt_nxt),
    .lim_q    (lim_q),
    .hit_q    (thr_hit),
    .clr_q    (stat_clear)
  );

  assign bus_rdata = {lim_q, cnt_q};
endmodule

// File: rtl/errcnt_chk.sv
module errcnt_chk #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned REG_W = 2 * CNT_W,
  localparam int unsigned NB_ALL = REG_W / 8,
  localparam int unsigned NB_HALF = NB_ALL / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_err,
  input logic              bus_we,
  input logic [NB_ALL-1:0] bus_be,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              thr_hit,
  input logic              stat_clear,
  input logic              cnt_clr_w,
  input logic              inc_done_w
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             lim_wr;
  assign cnt    = bus_rdata[CNT_W-1:0];
  assign lim    = bus_rdata[REG_W-1:CNT_W];
  assign lim_wr = bus_we && (|bus_be[NB_ALL-1:NB_HALF]);

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !cnt_clr_w && cnt != '1) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !cnt_clr_w) |=> cnt == '1);

  p_no_inc_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |-> !inc_done_w);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_w |=> cnt == '0);

  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_w |=> stat_clear);

  p_clr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_w |=> !stat_clear);

  p_thr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_wr |=> $stable(lim));

  p_hit_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_hit) |-> (cnt == $past(lim)) && ($past(lim) != '0));

  p_hit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0) |=> !thr_hit);

  p_hit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> !thr_hit);
endmodule

bind err_thresh_counter errcnt_chk #(.CNT_W(CNT_W)) u_errcnt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_err     (ev_err),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .bus_rdata  (bus_rdata),
  .thr_hit    (thr_hit),
  .stat_clear (stat_clear),
  .cnt_clr_w  (cnt_clr_w),
  .inc_done_w (inc_done_w)
);

// File: tb/test_err_thresh_counter.sv
`timescale 1ns/1ps
module test_err_thresh_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_err = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        thr_hit;
  logic        stat_clear;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  err_thresh_counter i_err_thresh_counter (
    .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .thr_hit(thr_hit), .stat_clear(stat_clear)
  );

  typedef struct packed {
    logic        ev;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [15:0] cnt;
    logic [15:0] thr;
    logic        hit;
    logic        clr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 4'b1100, 32'h0003_0000, 16'd0, 16'h0003, 1'b0, 1'b0}, // R6 threshold set
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd1, 16'h0003, 1'b0, 1'b0}, // R3
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd2, 16'h0003, 1'b0, 1'b0},
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd3, 16'h0003, 1'b1, 1'b0}, // R7 reach
    '{1'b0, 1'b0, 4'b0000, 32'h0,         16'd3, 16'h0003, 1'b0, 1'b0}, // R7 one cycle
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd4, 16'h0003, 1'b0, 1'b0},
    '{1'b1, 1'b1, 4'b0011, 32'h0000_1234, 16'd0, 16'h0003, 1'b0, 1'b1}, // R4 strobe+clear, R5
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd1, 16'h0003, 1'b0, 1'b0},
    '{1'b1, 1'b1, 4'b1100, 32'h0000_0000, 16'd2, 16'h0000, 1'b0, 1'b0}, // R6 count kept
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd3, 16'h0000, 1'b0, 1'b0}, // R8 no hit at zero
    '{1'b0, 1'b1, 4'b0100, 32'hFF05_0000, 16'd3, 16'h0005, 1'b0, 1'b0}, // R6 low byte only
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd4, 16'h0005, 1'b0, 1'b0},
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd5, 16'h0005, 1'b1, 1'b0}, // R7
    '{1'b0, 1'b1, 4'b1000, 32'h0177_0000, 16'd5, 16'h0105, 1'b0, 1'b0}, // R6 high byte only
    '{1'b0, 1'b1, 4'b0001, 32'h0,         16'd0, 16'h0105, 1'b0, 1'b1}, // R4, R5
    '{1'b1, 1'b0, 4'b0000, 32'h0,         16'd1, 16'h0105, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ev, input logic we, input logic [3:0] be,
                      input logic [31:0] wd);
    @(negedge clk);
    ev_err = ev; bus_we = we; bus_be = be; bus_wdata = wd;
    @(posedge clk);
    #1;
    ev_err = 1'b0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    int hits;
    repeat (3) @(posedge clk);
    #1;
    check(bus_rdata == 32'h0, "R1 register in reset", bus_rdata, 32'h0);
    check(thr_hit == 1'b0, "R1 hit in reset", thr_hit, 0);
    check(stat_clear == 1'b0, "R1 clear in reset", stat_clear, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check(bus_rdata == 32'h0, "R1 register after reset", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ev, VEC[i].we, VEC[i].be, VEC[i].wd);
      check(bus_rdata[15:0] == VEC[i].cnt, $sformatf("R2,R3,R4 count row %0d", i),
            bus_rdata[15:0], VEC[i].cnt);
      check(bus_rdata[31:16] == VEC[i].thr, $sformatf("R2,R6 threshold row %0d", i),
            bus_rdata[31:16], VEC[i].thr);
      check(thr_hit == VEC[i].hit, $sformatf("R7,R8 hit row %0d", i),
            thr_hit, VEC[i].hit);
      check(stat_clear == VEC[i].clr, $sformatf("R5 clear row %0d", i),
            stat_clear, VEC[i].clr);
    end

    // R1: reset mid-run returns everything to zero
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(bus_rdata == 32'h0, "R1 async reset", bus_rdata, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R9 and R3: run to saturation with threshold 0xFFFF
    step(1'b0, 1'b1, 4'b1100, 32'hFFFF_0000);
    check(bus_rdata == 32'hFFFF_0000, "R6 full threshold", bus_rdata, 32'hFFFF_0000);
    hits = 0;
    for (int k = 0; k < 65535 + 4; k++) begin
      step(1'b1, 1'b0, 4'b0000, 32'h0);
      if (thr_hit) hits++;
    end
    check(bus_rdata[15:0] == 16'hFFFF, "R3 saturation", bus_rdata[15:0], 16'hFFFF);
    check(hits == 1, "R9 single hit at saturation", hits, 1);
    step(1'b0, 1'b0, 4'b0000, 32'h0);
    check(thr_hit == 1'b0, "R9 no repeat", thr_hit, 0);
    step(1'b1, 1'b1, 4'b0010, 32'h0);
    check(bus_rdata[15:0] == 16'h0, "R4 clear from saturation", bus_rdata[15:0], 0);
    check(stat_clear == 1'b1, "R5 clear pulse", stat_clear, 1);
    step(1'b0, 1'b0, 4'b0000, 32'h0);
    check(stat_clear == 1'b0, "R5 clear pulse ends", stat_clear, 0);

    finish_run();
  end
endmodule